// File: doc/BRIEF.md
# Aligned Divide-by-2/4/8 Clock Bank

This block turns one input clock into three slower clocks at one half, one quarter and one eighth of the input rate. Each divided clock leaves the block as a pair of pins, a true output and its inverse. All three are the bits of a single 3-bit counter that steps on rising input edges. Whenever two or more outputs change in the same period, they therefore change on the same edge.

Division is paused by driving `en` high and resumed by driving it low. The pin is never used directly. A register captures it on the falling clock edge, and only that captured value decides whether the next rising edge advances the counter. A pause or a restart therefore takes effect only while the clock is low, and no shortened output pulse can appear.

The master reset `mr` is active high and asynchronous. It clears the counter and the captured enable. All true outputs then read low and all complements high. Releasing `mr` on the same edge in several instances brings their outputs into step.

Top module: `clkdiv_bank`

## Requirements
- R1: Over 16 consecutive advancing rising edges, q0 rises 8 times, q1 rises 4 times and q2 rises 2 times, so each output runs at 1/2, 1/4 and 1/8 of the input rate with a 50% duty cycle.
- R2: Whenever q2 changes, q1 and q0 change on the same rising edge. Whenever q1 changes, q0 changes on the same rising edge.
- R3: When the captured enable is low and `mr` is low, each rising edge adds one (modulo 8) to the value {q2,q1,q0}, with q0 as the least significant bit.
- R4: When the captured enable is high and `mr` is low, a rising edge leaves every output unchanged.
- R5: While `mr` is high, q0, q1 and q2 read 0 and q0n, q1n and q2n read 1 at once, without waiting for a clock edge, whatever `en` and `clk` do.
- R6: Outside reset, each complement output is always the inverse of its true output.
- R7: A rising edge acts on the value `en` had at the most recent falling edge. A change of `en` while the clock is low does not affect the rising edge that immediately follows it.
- R8: No output pulse, high or low, is shorter than one input clock period, however `en` is toggled.
- R9: After `mr` is released with `en` low, q0 first rises on the first rising edge, q1 on the second and q2 on the fourth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| en | input | 1 | Division pause, active high, captured on the falling edge |
| mr | input | 1 | Asynchronous master reset, active high |
| q0 | output | 1 | Divide-by-2 true output |
| q0n | output | 1 | Divide-by-2 complement output |
| q1 | output | 1 | Divide-by-4 true output |
| q1n | output | 1 | Divide-by-4 complement output |
| q2 | output | 1 | Divide-by-8 true output |
| q2n | output | 1 | Divide-by-8 complement output |

## Verification
An `en` level set while the clock is high is captured at the next falling edge, and the outputs reflect it after the rising edge that follows. An `en` change made while the clock is low waits one more full period. The driver therefore advances its own model of the captured enable at each falling edge and of the counter at each rising edge. It queues the expected outputs at that rising edge, and the monitor compares them two time units later, after the counter register has settled. Reset has no latency, so its checks are made one time unit after `mr` rises, in the clock-low phase, and again after several edges with `mr` still high.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned DIV_STAGES = 3;
  typedef logic [DIV_STAGES-1:0] div_cnt_t;

  // next counter value: hold when paused, otherwise step by one (wraps)
  function automatic div_cnt_t div_next(input div_cnt_t cur, input logic paused);
    div_cnt_t nxt;
    if (paused) nxt = cur;
    else        nxt = cur + div_cnt_t'(1);
    return nxt;
  endfunction
endpackage

// File: rtl/clkdiv_en_capture.sv
// Captures the pause request on the falling clock edge so that gating
// changes only while the clock is low.
module clkdiv_en_capture (
  input  logic clk,
  input  logic mr,
  input  logic en,
  output logic en_q
);
  always_ff @(negedge clk or posedge mr) begin
    if (mr) en_q <= 1'b0;
    else    en_q <= en;
  end
endmodule

// File: rtl/clkdiv_counter.sv
// Shared divide counter; every output bit comes from this one register.
module clkdiv_counter #(
  parameter int unsigned WIDTH = clkdiv_pkg::DIV_STAGES
) (
  input  logic             clk,
  input  logic             mr,
  input  logic             paused,
  output logic [WIDTH-1:0] cnt
);
  localparam logic [WIDTH-1:0] CNT_ZERO = '0;

  always_ff @(posedge clk or posedge mr) begin
    if (mr)          cnt <= CNT_ZERO;
    else if (!paused) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/clkdiv_diff_out.sv
// Forms a true/complement pair for every counter bit.
module clkdiv_diff_out #(
  parameter int unsigned WIDTH = clkdiv_pkg::DIV_STAGES
) (
  input  logic [WIDTH-1:0] cnt,
  output logic [WIDTH-1:0] q_t,
  output logic [WIDTH-1:0] q_c
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pair
    assign q_t[i] = cnt[i];
    assign q_c[i] = ~cnt[i];
  end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank (
  input  logic clk,
  input  logic en,
  input  logic mr,
  output logic q0,
  output logic q0n,
  output logic q1,
  output logic q1n,
  output logic q2,
  output logic q2n
);
  import clkdiv_pkg::*;
  localparam int unsigned W = DIV_STAGES;

  // named internal events for the checker
  logic        en_q;   // pause request as seen by the rising edge
  logic        adv;    // this rising edge steps the counter
  div_cnt_t    cnt;
  logic [W-1:0] q_t;
  logic [W-1:0] q_c;

  clkdiv_en_capture u_en (
    .clk  (clk),
    .mr   (mr),
    .en   (en),
    .en_q (en_q)
  );

  assign adv = ~en_q;

  clkdiv_counter #(.WIDTH(W)) u_cnt (
    .clk    (clk),
    .mr     (mr),
    .paused (~adv),
    .cnt    (cnt)
  );

  clkdiv_diff_out #(.WIDTH(W)) u_out (
    .cnt (cnt),
    .q_t (q_t),
    .q_c (q_c)
  );

  assign q0  = q_t[0];
  assign q0n = q_c[0];
  assign q1  = q_t[1];
  assign q1n = q_c[1];
  assign q2  = q_t[2];
  assign q2n = q_c[2];
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk (
  input logic clk,
  input logic mr,
  input logic en_q,
  input logic q0,
  input logic q0n,
  input logic q1,
  input logic q1n,
  input logic q2,
  input logic q2n
);
  assert_shared_edges_R2: assert property (@(posedge clk) disable iff (mr)
    !$stable(q2) |-> (!$stable(q1) && !$stable(q0)));

  assert_shared_edges_b_R2: assert property (@(posedge clk) disable iff (mr)
    !$stable(q1) |-> !$stable(q0));

  assert_step_R3: assert property (@(posedge clk) disable iff (mr)
    !en_q |=> ({q2, q1, q0} == 3'($past({q2, q1, q0}) + 3'd1)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (mr)
    en_q |=> $stable({q2, q1, q0}));

  assert_reset_R5: assert property (@(posedge clk)
    mr |-> ({q2, q1, q0} == 3'b000 && {q2n, q1n, q0n} == 3'b111));

  assert_pairs_R6: assert property (@(posedge clk) disable iff (mr)
    (q0 ^ q0n) && (q1 ^ q1n) && (q2 ^ q2n));
endmodule

bind clkdiv_bank clkdiv_bank_chk u_chk (
  .clk  (clk),
  .mr   (mr),
  .en_q (en_q),
  .q0   (q0),
  .q0n  (q0n),
  .q1   (q1),
  .q1n  (q1n),
  .q2   (q2),
  .q2n  (q2n)
);

// File: tb/tb_clkdiv_bank.sv
module tb_clkdiv_bank;
  localparam int PERIOD = 10;

  typedef struct {
    logic [2:0] exp;
    string      tag;
  } sb_item_t;

  logic clk = 1'b0;
  logic en  = 1'b0;
  logic mr  = 1'b1;
  logic q0, q0n, q1, q1n, q2, q2n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sb_item_t   sb[$];
  logic [2:0] model_cnt = 3'd0;
  logic       model_enq = 1'b0;

  // edge tracking for R1, R2, R8
  logic [2:0] prev_q = 3'd0;
  time        last_t[3];
  bit         t_valid[3];
  int         rises[3];
  int         align_bad = 0;
  int         runt_bad  = 0;

  clkdiv_bank dut (
    .clk (clk), .en (en), .mr (mr),
    .q0 (q0), .q0n (q0n), .q1 (q1), .q1n (q1n), .q2 (q2), .q2n (q2n)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_reset(input string tag);
    check({q2, q1, q0} == 3'b000 && {q2n, q1n, q0n} == 3'b111, tag,
          {q2n, q1n, q0n, q2, q1, q0}, 6'b111000);
  endtask

  // driver: one clock period starting just after a rising edge
  task automatic cyc(input logic e_hi, input logic late, input logic e_lo, input string tag);
    en = e_hi;
    @(negedge clk);
    model_enq = en;
    if (late) begin
      #1;
      en = e_lo;
    end
    @(posedge clk);
    if (!model_enq) model_cnt = model_cnt + 3'd1;
    sb.push_back('{exp: model_cnt, tag: tag});
    #1;
  endtask

  // monitor
  always @(posedge clk) begin
    logic [2:0] cur;
    #2;
    cur = {q2, q1, q0};
    if (sb.size() > 0) begin
      sb_item_t it;
      it = sb.pop_front();
      check(cur == it.exp && {q2n, q1n, q0n} == ~it.exp, it.tag,
            {q2n, q1n, q0n, cur}, {~it.exp, it.exp});
    end
    if (mr) begin
      for (int i = 0; i < 3; i++) t_valid[i] = 0;
    end else begin
      if (cur[2] != prev_q[2] && (cur[1] == prev_q[1] || cur[0] == prev_q[0])) align_bad++;
      if (cur[1] != prev_q[1] && cur[0] == prev_q[0]) align_bad++;
      for (int i = 0; i < 3; i++) begin
        if (cur[i] != prev_q[i]) begin
          if (t_valid[i] && ($time - last_t[i]) < PERIOD) runt_bad++;
          last_t[i]  = $time;
          t_valid[i] = 1;
          if (cur[i]) rises[i]++;
        end
      end
    end
    prev_q = cur;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int r0[3];
    for (int i = 0; i < 3; i++) begin rises[i] = 0; t_valid[i] = 0; end

    // R5: state while reset is held from power-up
    repeat (2) @(posedge clk);
    #2;
    check_reset("R5");
    en = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    check_reset("R5");

    // release with en low: R9 start-up order
    @(posedge clk);
    #1;
    en = 1'b0;
    mr = 1'b0;
    model_cnt = 3'd0;
    model_enq = 1'b0;
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0, "R9");

    // R1 window over 16 advancing edges (also R3)
    #2;
    for (int i = 0; i < 3; i++) r0[i] = rises[i];
    for (int i = 0; i < 16; i++) cyc(1'b0, 1'b0, 1'b0, "R3");
    #2;
    check(rises[0] - r0[0] == 8, "R1 div2", rises[0] - r0[0], 8);
    check(rises[1] - r0[1] == 4, "R1 div4", rises[1] - r0[1], 4);
    check(rises[2] - r0[2] == 2, "R1 div8", rises[2] - r0[2], 2);

    // R4: pause
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 1'b0, "R4");

    // R7: changes in the low phase wait for the next falling edge
    cyc(1'b0, 1'b1, 1'b1, "R7");
    cyc(1'b1, 1'b0, 1'b0, "R4");
    cyc(1'b1, 1'b1, 1'b0, "R7");
    cyc(1'b0, 1'b0, 1'b0, "R3");

    // mixed toggling in both phases
    for (int i = 0; i < 30; i++)
      cyc(logic'(i % 3 == 0), logic'(i % 2), logic'(i % 5 == 1), "R3");

    // R5: asynchronous reset in the clock-low phase
    @(negedge clk);
    #2;
    mr = 1'b1;
    #1;
    check_reset("R5 async");
    en = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check_reset("R5 held");
    model_cnt = 3'd0;
    model_enq = 1'b0;
    @(posedge clk);
    #1;
    mr = 1'b0;
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, "R4");
    for (int i = 0; i < 8; i++) cyc(1'b0, 1'b0, 1'b0, "R6");

    #(PERIOD);
    check(align_bad == 0, "R2", align_bad, 0);
    check(runt_bad == 0, "R8", runt_bad, 0);
    check(sb.size() == 0, "R3 queue drained", sb.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule